// File: doc/BRIEF.md
# Timer Compare Output Waveform Unit

This block is one channel of an 8-bit timer. It has a free-running counter, one compare register and one waveform output pin. A 2-bit waveform mode selects how the counter runs:

- plain wrap-around counting,
- clear-on-TOP counting,
- single-slope PWM (counting up only),
- dual-slope PWM (counting up and then down).

A 2-bit output mode selects what a compare match, the BOTTOM count or the TOP count does to the pin. The mode pair is decoded jointly. Toggle exists only outside the PWM modes, and output mode 01 is reserved in both PWM modes.

In the PWM modes the compare value is double-buffered. A new value takes effect only at TOP, so an update never produces a partial pulse. When the compare value equals TOP, the match edge is suppressed. The edge then happens at BOTTOM in single-slope PWM, or at TOP in dual-slope PWM. When the pin is not driven by the waveform logic, it carries a separate port data bit instead.

Top module: `tmr_wave_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter clears to 0, the direction becomes up, the compare buffer clears to 0 and the waveform register clears to 0.
- R2: `wave_mode` encoding is 00 normal, 01 clear-on-TOP, 10 single-slope PWM and 11 dual-slope PWM. Normal mode counts up and wraps from 255 to 0. Clear-on-TOP and single-slope PWM count from 0 up to `top_val` and then load 0. Dual-slope counts up to `top_val`, then down to 0, reversing at each end; this mode assumes `top_val` ≥ 1.
- R3: At an edge where `en` is low, the counter, its direction and the waveform register all hold, and no match acts.
- R4: With `out_mode` 00 in any waveform mode, `pin_connected` is 0, `pin_out` follows `port_data`, and the waveform register holds.
- R5: In modes 00 and 01, a match toggles the waveform register when `out_mode` is 01, clears it when `out_mode` is 10 and sets it when `out_mode` is 11. A match is an enabled edge where the count equals the active compare value. `pin_out` shows the result from the cycle after that edge.
- R6: In single-slope PWM, `out_mode` 10 clears the register on a match and sets it at count 0 (BOTTOM). `out_mode` 11 does the reverse. If a match and BOTTOM fall on the same edge, the match action wins.
- R7: In single-slope PWM with `out_mode[1]` set and the compare value equal to `top_val`, the match is ignored and only the BOTTOM action is applied.
- R8: In dual-slope PWM, `out_mode` 10 clears the register on a match while counting up and sets it on a match while counting down; `out_mode` 11 does the reverse. The edge at TOP counts as counting up.
- R9: In dual-slope PWM with `out_mode[1]` set and the compare value equal to `top_val`, the match is ignored. At the TOP edge the register is set for `out_mode` 10 and cleared for `out_mode` 11.
- R10: `out_mode` 01 in either PWM mode is reserved: `pin_connected` is 0, `pin_out` follows `port_data`, and the waveform register holds.
- R11: In the PWM modes the active compare value is a buffer that loads `cmp_val` only at an enabled edge where the count equals `top_val`. In modes 00 and 01, `cmp_val` is used directly, and the buffer tracks it on every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Count enable; when low, the counter and the output hold |
| wave_mode | input | 2 | 00 normal, 01 clear-on-TOP, 10 single-slope PWM, 11 dual-slope PWM |
| out_mode | input | 2 | Compare output action select |
| cmp_val | input | 8 | Compare value |
| top_val | input | 8 | TOP value for clear-on-TOP and the PWM modes |
| port_data | input | 1 | Pin value used while the waveform logic is disconnected |
| pin_out | output | 1 | Waveform pin |
| pin_connected | output | 1 | High when the waveform register drives the pin |
| count | output | 8 | Current counter value |

## Verification
The counter and the waveform register each sit one register stage from the inputs. An action caused by the count seen at clock edge K therefore appears on `pin_out` and `count` immediately after edge K, while `pin_connected` is combinational from the mode inputs. The bench changes inputs at the falling edge, applies a known number of rising edges after a fixed reset-and-preload sequence, and samples at the next falling edge. Each expected count and pin level is derived by hand from the count sequence seen at each edge. Directed sequences cover compare changes in the middle of a period and hold cycles with a pending match, and count the edges the same way.

// File: rtl/tmr_pkg.sv
// Shared types for the timer compare output unit.
// Assumes nothing beyond a 2-bit waveform mode encoding.
package tmr_pkg;
    typedef enum logic [1:0] {
        WM_NORMAL = 2'b00,
        WM_CTC    = 2'b01,
        WM_FAST   = 2'b10,
        WM_PHASE  = 2'b11
    } wmode_e;
endpackage

// File: rtl/tmr_counter.sv
// Timer counter: wrap, clear-on-TOP, single-slope or dual-slope counting.
// Assumes top >= 1 in dual-slope mode; top == 0 there parks the count at 0.
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  wmode_e       mode,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt,
    output logic         cnt_down,
    output logic         at_top,
    output logic         at_bottom
);
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] ZERO = '0;

    logic [W-1:0] cnt_q, cnt_d;
    logic         down_q, down_d;

    // Next count and direction for the selected waveform mode.
    always_comb begin
        cnt_d  = cnt_q + ONE;
        down_d = 1'b0;
        case (mode)
            WM_CTC, WM_FAST: cnt_d = (cnt_q == top) ? ZERO : cnt_q + ONE;
            WM_PHASE: begin
                if (top == ZERO) begin
                    cnt_d  = ZERO;
                    down_d = 1'b0;
                end else if (!down_q) begin
                    down_d = (cnt_q == top);
                    cnt_d  = (cnt_q == top) ? cnt_q - ONE : cnt_q + ONE;
                end else begin
                    down_d = (cnt_q != ZERO);
                    cnt_d  = (cnt_q == ZERO) ? ONE : cnt_q - ONE;
                end
            end
            default: cnt_d = cnt_q + ONE;
        endcase
    end

    // Count register: cleared by reset, advanced only when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= ZERO;
            down_q <= 1'b0;
        end else if (en) begin
            cnt_q  <= cnt_d;
            down_q <= down_d;
        end
    end

    assign cnt       = cnt_q;
    assign cnt_down  = down_q;
    assign at_top    = (cnt_q == top);
    assign at_bottom = (cnt_q == ZERO);

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt_q) && $stable(down_q));
    assert_clear_at_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (mode == WM_CTC || mode == WM_FAST) && cnt_q == top) |=> cnt_q == ZERO);
    assert_reverse_at_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == WM_PHASE && !down_q && cnt_q == top && top != ZERO) |=> down_q);
endmodule

// File: rtl/tmr_compare.sv
// Compare stage: holds the double buffer and detects matches.
// Assumes the buffer should track the input whenever a non-PWM mode is active.
module tmr_compare
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  wmode_e       mode,
    input  logic [W-1:0] cmp_in,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] top,
    input  logic         at_top,
    output logic         match,
    output logic         cmp_is_top
);
    logic [W-1:0] buf_q;
    logic [W-1:0] active;
    logic         pwm;

    assign pwm = mode[1];

    // Compare buffer: follows the input outside PWM, loads at TOP in PWM.
    always_ff @(posedge clk) begin
        if (!rst_n)                buf_q <= '0;
        else if (!pwm || (en && at_top)) buf_q <= cmp_in;
    end

    assign active     = pwm ? buf_q : cmp_in;
    assign match      = en && (cnt == active);
    assign cmp_is_top = (active == top);

    assert_buffer_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && en && !at_top) |=> $stable(buf_q));
endmodule

// File: rtl/tmr_wave_out.sv
// Output stage: decodes waveform mode with output mode into pin actions.
// Assumes match, at_top, at_bottom and cnt_down describe the same count.
module tmr_wave_out
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  wmode_e     mode,
    input  logic [1:0] out_mode,
    input  logic       match,
    input  logic       cmp_is_top,
    input  logic       at_top,
    input  logic       at_bottom,
    input  logic       cnt_down,
    input  logic       port_data,
    output logic       pin,
    output logic       connected
);
    logic wave_q, wave_d;

    // Next waveform level from the joint mode decode.
    always_comb begin
        wave_d = wave_q;
        if (en) begin
            case (mode)
                WM_FAST: begin
                    if (out_mode[1]) begin
                        if (match && !cmp_is_top) wave_d = out_mode[0];
                        else if (at_bottom)       wave_d = ~out_mode[0];
                    end
                end
                WM_PHASE: begin
                    if (out_mode[1]) begin
                        if (cmp_is_top) begin
                            if (at_top) wave_d = ~out_mode[0];
                        end else if (match) begin
                            wave_d = out_mode[0] ^ cnt_down;
                        end
                    end
                end
                default: begin
                    if (match) begin
                        case (out_mode)
                            2'b01:   wave_d = ~wave_q;
                            2'b10:   wave_d = 1'b0;
                            2'b11:   wave_d = 1'b1;
                            default: wave_d = wave_q;
                        endcase
                    end
                end
            endcase
        end
    end

    // Waveform register: cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) wave_q <= 1'b0;
        else        wave_q <= wave_d;
    end

    assign connected = (out_mode != 2'b00) && !(mode[1] && out_mode == 2'b01);
    assign pin       = connected ? wave_q : port_data;

    assert_disc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == 2'b00) |=> $stable(wave_q));
    assert_reserved_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && out_mode == 2'b01) |=> $stable(wave_q));
    assert_set_on_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode[1] && out_mode == 2'b11 && match) |=> wave_q);
    assert_top_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == WM_FAST && out_mode[1] && cmp_is_top && !at_bottom) |=> $stable(wave_q));
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(wave_q));
endmodule

// File: rtl/tmr_wave_unit.sv
// Timer compare output waveform unit: counter, compare stage and output stage.
// Assumes synchronous active-low reset; all inputs are synchronous to clk.
module tmr_wave_unit
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [1:0]   wave_mode,
    input  logic [1:0]   out_mode,
    input  logic [W-1:0] cmp_val,
    input  logic [W-1:0] top_val,
    input  logic         port_data,
    output logic         pin_out,
    output logic         pin_connected,
    output logic [W-1:0] count
);
    wmode_e       mode;
    logic [W-1:0] cnt;
    logic         cnt_down, at_top, at_bottom, match, cmp_is_top;

    assign mode  = wmode_e'(wave_mode);
    assign count = cnt;

    tmr_counter #(.W(W)) u_counter (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .top(top_val),
        .cnt(cnt), .cnt_down(cnt_down), .at_top(at_top), .at_bottom(at_bottom)
    );

    tmr_compare #(.W(W)) u_compare (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .cmp_in(cmp_val),
        .cnt(cnt), .top(top_val), .at_top(at_top),
        .match(match), .cmp_is_top(cmp_is_top)
    );

    tmr_wave_out u_wave (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .out_mode(out_mode),
        .match(match), .cmp_is_top(cmp_is_top), .at_top(at_top),
        .at_bottom(at_bottom), .cnt_down(cnt_down), .port_data(port_data),
        .pin(pin_out), .connected(pin_connected)
    );

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0) && !cnt_down);
endmodule

// File: tb/tb_tmr_wave_unit.sv
`timescale 1ns/1ps
module tb_tmr_wave_unit;
    logic       clk = 1'b0;
    logic       rst_n, en, port_data;
    logic [1:0] wave_mode, out_mode;
    logic [7:0] cmp_val, top_val;
    logic       pin_out, pin_connected;
    logic [7:0] count;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    tmr_wave_unit dut (
        .clk(clk), .rst_n(rst_n), .en(en), .wave_mode(wave_mode),
        .out_mode(out_mode), .cmp_val(cmp_val), .top_val(top_val),
        .port_data(port_data), .pin_out(pin_out),
        .pin_connected(pin_connected), .count(count)
    );

    typedef struct packed {
        logic [3:0] req;
        logic [1:0] wm;
        logic [1:0] om;
        logic [7:0] cmp;
        logic [7:0] top;
        logic       pd;
        logic [8:0] k;
        logic [7:0] ecnt;
        logic       epin;
        logic       econ;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{4'd5,  2'd0, 2'd1, 8'd3, 8'd255, 1'b0, 9'd4,   8'd4, 1'b1, 1'b1}, // R5 toggle
        '{4'd5,  2'd0, 2'd1, 8'd3, 8'd255, 1'b0, 9'd3,   8'd3, 1'b0, 1'b1}, // R5 before match
        '{4'd2,  2'd0, 2'd1, 8'd3, 8'd255, 1'b0, 9'd260, 8'd4, 1'b0, 1'b1}, // R2 wrap at 255
        '{4'd2,  2'd1, 2'd3, 8'd2, 8'd5,   1'b0, 9'd6,   8'd0, 1'b1, 1'b1}, // R2 clear-on-TOP
        '{4'd5,  2'd1, 2'd1, 8'd2, 8'd5,   1'b0, 9'd9,   8'd3, 1'b0, 1'b1}, // R5 two toggles
        '{4'd6,  2'd2, 2'd2, 8'd4, 8'd9,   1'b0, 9'd1,   8'd1, 1'b1, 1'b1}, // R6 set at BOTTOM
        '{4'd6,  2'd2, 2'd2, 8'd4, 8'd9,   1'b0, 9'd5,   8'd5, 1'b0, 1'b1}, // R6 clear on match
        '{4'd6,  2'd2, 2'd2, 8'd4, 8'd9,   1'b0, 9'd11,  8'd1, 1'b1, 1'b1}, // R6 next period
        '{4'd6,  2'd2, 2'd3, 8'd4, 8'd9,   1'b0, 9'd5,   8'd5, 1'b1, 1'b1}, // R6 inverting
        '{4'd7,  2'd2, 2'd2, 8'd9, 8'd9,   1'b0, 9'd10,  8'd0, 1'b1, 1'b1}, // R7 match at TOP ignored
        '{4'd10, 2'd2, 2'd1, 8'd4, 8'd9,   1'b1, 9'd5,   8'd5, 1'b1, 1'b0}, // R10 reserved, single-slope
        '{4'd8,  2'd3, 2'd3, 8'd3, 8'd6,   1'b0, 9'd9,   8'd3, 1'b1, 1'b1}, // R8 set while up
        '{4'd8,  2'd3, 2'd3, 8'd3, 8'd6,   1'b0, 9'd10,  8'd2, 1'b0, 1'b1}, // R8 clear while down
        '{4'd8,  2'd3, 2'd2, 8'd3, 8'd6,   1'b0, 9'd10,  8'd2, 1'b1, 1'b1}, // R8 set while down
        '{4'd2,  2'd3, 2'd2, 8'd3, 8'd6,   1'b0, 9'd13,  8'd1, 1'b1, 1'b1}, // R2 reverse at 0
        '{4'd9,  2'd3, 2'd2, 8'd6, 8'd6,   1'b0, 9'd7,   8'd5, 1'b1, 1'b1}, // R9 set at TOP
        '{4'd9,  2'd3, 2'd2, 8'd6, 8'd6,   1'b0, 9'd6,   8'd6, 1'b0, 1'b1}, // R9 not before TOP
        '{4'd4,  2'd0, 2'd0, 8'd3, 8'd255, 1'b1, 9'd4,   8'd4, 1'b1, 1'b0}, // R4 normal, port high
        '{4'd4,  2'd2, 2'd0, 8'd4, 8'd9,   1'b0, 9'd5,   8'd5, 1'b0, 1'b0}, // R4 single-slope
        '{4'd10, 2'd3, 2'd1, 8'd3, 8'd6,   1'b1, 9'd4,   8'd4, 1'b1, 1'b0}  // R10 reserved, dual-slope
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reset with mode 00, one preload edge, then select the mode and enable.
    task automatic start(input logic [1:0] wm, input logic [1:0] om,
                         input logic [7:0] cmp, input logic [7:0] top, input logic pd);
        rst_n = 1'b0; en = 1'b0; wave_mode = 2'd0;
        out_mode = om; cmp_val = cmp; top_val = top; port_data = pd;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        wave_mode = wm; en = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; en = 1'b0; wave_mode = 2'd2; out_mode = 2'd2;
        cmp_val = 8'd4; top_val = 8'd9; port_data = 1'b1;
        tick(3);
        // R1: reset state seen at the ports
        chk("R1 count", count, 0);
        chk("R1 pin", pin_out, 0);
        chk("R1 connected", pin_connected, 1);

        for (int i = 0; i < NV; i++) begin
            start(TBL[i].wm, TBL[i].om, TBL[i].cmp, TBL[i].top, TBL[i].pd);
            tick(int'(TBL[i].k));
            chk($sformatf("R%0d vec%0d count", TBL[i].req, i), count, int'(TBL[i].ecnt));
            chk($sformatf("R%0d vec%0d pin", TBL[i].req, i), pin_out, int'(TBL[i].epin));
            chk($sformatf("R%0d vec%0d connected", TBL[i].req, i), pin_connected, int'(TBL[i].econ));
        end

        // R3: disabled edges hold the count; a pending match does not act
        start(2'd0, 2'd1, 8'd3, 8'd255, 1'b0);
        tick(3);
        en = 1'b0;
        tick(5);
        chk("R3 hold count", count, 3);
        chk("R3 no action", pin_out, 0);
        en = 1'b1;
        tick(1);
        chk("R3 resume count", count, 4);
        chk("R3 resume toggle", pin_out, 1);

        // R11: a non-PWM compare change takes effect immediately
        start(2'd0, 2'd1, 8'd3, 8'd255, 1'b0);
        tick(2);
        cmp_val = 8'd2;
        tick(1);
        chk("R11 immediate", pin_out, 1);

        // R11: a PWM compare change waits for TOP
        start(2'd2, 2'd2, 8'd4, 8'd9, 1'b0);
        tick(3);
        cmp_val = 8'd7;
        tick(2);
        chk("R11 old compare", pin_out, 0);
        tick(6);
        chk("R11 bottom count", count, 1);
        chk("R11 bottom set", pin_out, 1);
        tick(6);
        chk("R11 before new match", pin_out, 1);
        tick(1);
        chk("R11 new compare", pin_out, 0);

        // R1: reset in mid-run clears the count and pin
        rst_n = 1'b0;
        tick(1);
        chk("R1 mid-run count", count, 0);
        chk("R1 mid-run pin", pin_out, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule